// File: doc/BRIEF.md
# Instruction Field Decoder and Control Generator

This block sits at the front of a single-cycle 16-bit core. It receives the instruction word that was fetched in the current cycle and splits it into register indices and an immediate. From the opcode and the sub-opcode bit it also derives every control signal the datapath needs. These cover the ALU function, the two register-file write enables, the write-back source, the memory read and write strobes, the branch or jump kind, the halt request and the display strobe.

The word has two layouts. Both carry a 4-bit opcode in the top nibble, a 3-bit first-source index below it, and a sub-opcode in bit 0 that picks one of two paired operations. In register form, a second-source index follows the first. In immediate form, an 8-bit immediate fills the middle of the word. The first source register is always the destination. Multiply and divide also write the register after it, and that index wraps within the eight registers. The block holds no state. Its outputs follow the instruction word with no clock.

Top module: `insn_decode`

## Requirements
- R1: `rs_idx` equals insn[11:9], `rt_idx` equals insn[8:6], and `rs_next_idx` equals (`rs_idx` + 1) modulo 8, so index 7 gives 0.
- R2: `imm_val` is insn[8:1] sign-extended to 16 bits when the opcode (insn[15:12]) is 1000 and insn[0] is 1. For every other word it is insn[8:1] zero-extended.
- R3: Register ALU operations select `alu_op`, with `wr_a`=1, `wr_src`=0 (ALU result) and `b_imm`=0. The table is: opcode 0000 gives add=0 (insn[0]=0) or sub=1 (insn[0]=1). Opcode 0001 gives and=2 or nor=3. Opcode 0010 gives div=4 or mul=5. Opcode 0011 gives shift-right=6 or shift-left=7.
- R4: `wr_b` is 1 for div and mul (opcode 0010) and 0 for every other opcode.
- R5: Opcode 0100 with insn[0]=0 is load: `mem_rd`=1, `wr_a`=1, `wr_src`=1 (memory). With insn[0]=1 it is store: `mem_wr`=1, `wr_a`=0, `mem_rd`=0.
- R6: Opcode 1000 is add-immediate: `alu_op`=0, `b_imm`=1, `wr_a`=1. Opcode 1001 loads the immediate: `alu_op`=8 (pass operand B), `b_imm`=1, `wr_a`=1, `imm_val` zero-extended, and insn[0] has no effect.
- R7: `br_kind` gives the condition of a conditional branch, with no register write. Opcode 1010 gives 1 (value greater than zero, insn[0]=0) or 2 (less than zero, insn[0]=1). Opcode 1011 gives 3 (not zero, insn[0]=0) or 4 (zero, insn[0]=1).
- R8: Opcode 1101 gives `br_kind`=5 (jump to immediate). Opcode 0101 gives 6 (jump to register), with no write. Opcode 1100 gives 7 (jump and link), with `wr_a`=1 and `wr_src`=2 (return address). insn[0] has no effect on any of the three.
- R9: Opcode 0110 drives `halt`=1, and opcode 0111 drives `show`=1. Neither writes a register or touches memory. Each strobe is 0 for every other opcode.
- R10: Opcodes 1110 and 1111 assert none of `wr_a`, `wr_b`, `mem_rd`, `mem_wr`, `halt` or `show`, and give `br_kind`=0.
- R11: `mem_rd` and `mem_wr` are never both 1. `mem_wr` never coincides with a register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 16 | Instruction word fetched this cycle |
| rs_idx | output | 3 | First source and destination register index |
| rt_idx | output | 3 | Second source register index |
| rs_next_idx | output | 3 | Second destination index, rs+1 modulo 8 |
| imm_val | output | 16 | Extended immediate |
| alu_op | output | 4 | ALU function code |
| b_imm | output | 1 | ALU operand B is the immediate |
| wr_a | output | 1 | Write enable for register rs |
| wr_b | output | 1 | Write enable for register rs+1 |
| wr_src | output | 2 | Write-back source: 0 ALU, 1 memory, 2 return address |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| br_kind | output | 3 | Branch or jump kind, 0 for none |
| halt | output | 1 | Stop fetching |
| show | output | 1 | Send rs to the hex display |

## Verification
Every output is a combinational function of `insn`, so each result is due in the same cycle the word is applied, with zero register stages. The bench changes `insn` half a clock period away from the clock edge. It waits one time unit for the logic to settle and samples there, so no check depends on the order of processes at an edge. Each scenario sweeps the sub-opcode bit and the unused or immediate bits, which shows that the controls follow only the opcode and sub-opcode that the requirements name.

// File: rtl/idec_pkg.sv
package idec_pkg;
    localparam int WORD_W    = 16;
    localparam int OPC_W     = 4;
    localparam int REG_IDX_W = 3;
    localparam int IMM_W     = 8;
    localparam int OPC_LSB   = WORD_W - OPC_W;
    localparam int RS_LSB    = OPC_LSB - REG_IDX_W;
    localparam int RT_LSB    = RS_LSB - REG_IDX_W;

    typedef enum logic [3:0] {
        OPC_ADDSUB = 4'b0000,
        OPC_LOGIC  = 4'b0001,
        OPC_DIVMUL = 4'b0010,
        OPC_SHIFT  = 4'b0011,
        OPC_MEM    = 4'b0100,
        OPC_JREG   = 4'b0101,
        OPC_HALT   = 4'b0110,
        OPC_SHOW   = 4'b0111,
        OPC_ADDIMM = 4'b1000,
        OPC_LDIMM  = 4'b1001,
        OPC_BRSGN  = 4'b1010,
        OPC_BRZERO = 4'b1011,
        OPC_JLINK  = 4'b1100,
        OPC_JIMM   = 4'b1101,
        OPC_RSV0   = 4'b1110,
        OPC_RSV1   = 4'b1111
    } opcode_e;

    typedef enum logic [3:0] {
        ALU_ADD   = 4'd0,
        ALU_SUB   = 4'd1,
        ALU_AND   = 4'd2,
        ALU_NOR   = 4'd3,
        ALU_DIV   = 4'd4,
        ALU_MUL   = 4'd5,
        ALU_SRL   = 4'd6,
        ALU_SLL   = 4'd7,
        ALU_PASSB = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        WS_ALU  = 2'd0,
        WS_MEM  = 2'd1,
        WS_LINK = 2'd2
    } wr_src_e;

    typedef enum logic [2:0] {
        BR_NONE = 3'd0,
        BR_GTZ  = 3'd1,
        BR_LTZ  = 3'd2,
        BR_NEZ  = 3'd3,
        BR_EQZ  = 3'd4,
        BR_JIMM = 3'd5,
        BR_JREG = 3'd6,
        BR_JAL  = 3'd7
    } br_kind_e;

    typedef struct packed {
        alu_op_e  alu_op;
        logic     b_imm;
        logic     wr_a;
        logic     wr_b;
        wr_src_e  wr_src;
        logic     mem_rd;
        logic     mem_wr;
        br_kind_e br;
        logic     halt;
        logic     show;
        logic     sext;
    } ctl_t;
endpackage

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
(
    input  logic [WORD_W-1:0]    insn,
    output opcode_e              opcode,
    output logic [REG_IDX_W-1:0] rs,
    output logic [REG_IDX_W-1:0] rt,
    output logic [IMM_W-1:0]     imm_raw,
    output logic                 subop
);
    always_comb begin
        opcode  = opcode_e'(insn[WORD_W-1:OPC_LSB]);
        rs      = insn[OPC_LSB-1:RS_LSB];
        rt      = insn[RS_LSB-1:RT_LSB];
        imm_raw = insn[IMM_W:1];
        subop   = insn[0];
    end
endmodule

// File: rtl/idec_imm_ext.sv
module idec_imm_ext #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  imm_in,
    input  logic             sext,
    output logic [OUT_W-1:0] imm_out
);
    localparam int PAD_W = OUT_W - IN_W;

    logic fill_bit;

    always_comb begin
        fill_bit = sext & imm_in[IN_W-1];
        imm_out  = {{PAD_W{fill_bit}}, imm_in};
    end

    always_comb begin
        if (!sext) begin
            AST_ZEXT_UPPER_CLEAR: assert (imm_out[OUT_W-1:IN_W] == '0); // R2
        end
    end
endmodule

// File: rtl/idec_ctl_table.sv
module idec_ctl_table
    import idec_pkg::*;
(
    input  opcode_e opcode,
    input  logic    subop,
    output ctl_t    ctl
);
    ctl_t ctl_d;

    always_comb begin
        ctl_d        = '0;
        ctl_d.alu_op = ALU_ADD;
        ctl_d.wr_src = WS_ALU;
        ctl_d.br     = BR_NONE;
        unique case (opcode)
            OPC_ADDSUB: begin
                ctl_d.alu_op = subop ? ALU_SUB : ALU_ADD;
                ctl_d.wr_a   = 1'b1;
            end
            OPC_LOGIC: begin
                ctl_d.alu_op = subop ? ALU_NOR : ALU_AND;
                ctl_d.wr_a   = 1'b1;
            end
            OPC_DIVMUL: begin
                ctl_d.alu_op = subop ? ALU_MUL : ALU_DIV;
                ctl_d.wr_a   = 1'b1;
                ctl_d.wr_b   = 1'b1;
            end
            OPC_SHIFT: begin
                ctl_d.alu_op = subop ? ALU_SLL : ALU_SRL;
                ctl_d.wr_a   = 1'b1;
            end
            OPC_MEM: begin
                ctl_d.mem_rd = ~subop;
                ctl_d.mem_wr = subop;
                ctl_d.wr_a   = ~subop;
                ctl_d.wr_src = WS_MEM;
            end
            OPC_JREG: begin
                ctl_d.br = BR_JREG;
            end
            OPC_HALT: begin
                ctl_d.halt = 1'b1;
            end
            OPC_SHOW: begin
                ctl_d.show = 1'b1;
            end
            OPC_ADDIMM: begin
                ctl_d.b_imm = 1'b1;
                ctl_d.wr_a  = 1'b1;
                ctl_d.sext  = subop;
            end
            OPC_LDIMM: begin
                ctl_d.alu_op = ALU_PASSB;
                ctl_d.b_imm  = 1'b1;
                ctl_d.wr_a   = 1'b1;
            end
            OPC_BRSGN: begin
                ctl_d.br = subop ? BR_LTZ : BR_GTZ;
            end
            OPC_BRZERO: begin
                ctl_d.br = subop ? BR_EQZ : BR_NEZ;
            end
            OPC_JLINK: begin
                ctl_d.br     = BR_JAL;
                ctl_d.wr_a   = 1'b1;
                ctl_d.wr_src = WS_LINK;
            end
            OPC_JIMM: begin
                ctl_d.br = BR_JIMM;
            end
            default: begin
                ctl_d = ctl_d;
            end
        endcase
        ctl = ctl_d;
    end

    always_comb begin
        AST_MEM_EXCLUSIVE: assert (!(ctl.mem_rd && ctl.mem_wr)); // R11
        AST_STORE_NO_WRITE: assert (!(ctl.mem_wr && (ctl.wr_a || ctl.wr_b))); // R11
        if (ctl.wr_b) begin
            AST_WRB_NEEDS_WRA: assert (ctl.wr_a && (ctl.alu_op == ALU_DIV || ctl.alu_op == ALU_MUL)); // R4
        end
        if (ctl.halt || ctl.show) begin
            AST_STROBE_QUIET: assert (!ctl.wr_a && !ctl.mem_rd && !ctl.mem_wr && ctl.br == BR_NONE); // R9
        end
    end
endmodule

// File: rtl/insn_decode.sv
module insn_decode
    import idec_pkg::*;
(
    input  logic [15:0] insn,
    output logic [2:0]  rs_idx,
    output logic [2:0]  rt_idx,
    output logic [2:0]  rs_next_idx,
    output logic [15:0] imm_val,
    output logic [3:0]  alu_op,
    output logic        b_imm,
    output logic        wr_a,
    output logic        wr_b,
    output logic [1:0]  wr_src,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [2:0]  br_kind,
    output logic        halt,
    output logic        show
);
    opcode_e              opcode;
    logic [REG_IDX_W-1:0] rs;
    logic [REG_IDX_W-1:0] rt;
    logic [IMM_W-1:0]     imm_raw;
    logic                 subop;
    ctl_t                 ctl;
    logic [WORD_W-1:0]    imm_ext;

    idec_fields i_fields (
        .insn    (insn),
        .opcode  (opcode),
        .rs      (rs),
        .rt      (rt),
        .imm_raw (imm_raw),
        .subop   (subop)
    );

    idec_ctl_table i_ctl (
        .opcode (opcode),
        .subop  (subop),
        .ctl    (ctl)
    );

    idec_imm_ext #(
        .IN_W  (IMM_W),
        .OUT_W (WORD_W)
    ) i_ext (
        .imm_in  (imm_raw),
        .sext    (ctl.sext),
        .imm_out (imm_ext)
    );

    always_comb begin
        rs_idx      = rs;
        rt_idx      = rt;
        rs_next_idx = rs + REG_IDX_W'(1);
        imm_val     = imm_ext;
        alu_op      = ctl.alu_op;
        b_imm       = ctl.b_imm;
        wr_a        = ctl.wr_a;
        wr_b        = ctl.wr_b;
        wr_src      = ctl.wr_src;
        mem_rd      = ctl.mem_rd;
        mem_wr      = ctl.mem_wr;
        br_kind     = ctl.br;
        halt        = ctl.halt;
        show        = ctl.show;
    end

    always_comb begin
        AST_NEXT_IDX_WRAP: assert (3'(rs_next_idx - rs_idx) == 3'd1); // R1
        if (imm_val[15:8] != 8'h00) begin
            AST_SEXT_ONLY_ADDI: assert (insn[15:12] == 4'b1000 && insn[0]); // R2
        end
        if (insn[15:13] == 3'b111) begin
            AST_UNDEF_IS_NOP: assert (!wr_a && !wr_b && !mem_rd && !mem_wr && !halt && !show && br_kind == 3'd0); // R10
        end
    end
endmodule

// File: tb/test_insn_decode.sv
module test_insn_decode;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [15:0] insn;
    logic [2:0]  rs_idx, rt_idx, rs_next_idx;
    logic [15:0] imm_val;
    logic [3:0]  alu_op;
    logic        b_imm, wr_a, wr_b, mem_rd, mem_wr, halt, show;
    logic [1:0]  wr_src;
    logic [2:0]  br_kind;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_decode i_insn_decode (
        .insn        (insn),
        .rs_idx      (rs_idx),
        .rt_idx      (rt_idx),
        .rs_next_idx (rs_next_idx),
        .imm_val     (imm_val),
        .alu_op      (alu_op),
        .b_imm       (b_imm),
        .wr_a        (wr_a),
        .wr_b        (wr_b),
        .wr_src      (wr_src),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .br_kind     (br_kind),
        .halt        (halt),
        .show        (show)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s insn=%h actual=%h expected=%h", tag, insn, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] w);
        @(negedge clk);
        insn = w;
        #1;
    endtask

    function automatic logic [15:0] mk_r(input logic [3:0] op, input logic [2:0] s,
                                         input logic [2:0] t, input logic [4:0] pad, input logic sub);
        return {op, s, t, pad, sub};
    endfunction

    function automatic logic [15:0] mk_i(input logic [3:0] op, input logic [2:0] s,
                                         input logic [7:0] im, input logic sub);
        return {op, s, im, sub};
    endfunction

    task automatic chk_quiet(input string tag);
        chk({tag, " wr_a"}, 16'(wr_a), 16'd0);
        chk({tag, " wr_b"}, 16'(wr_b), 16'd0);
        chk({tag, " mem_rd"}, 16'(mem_rd), 16'd0);
        chk({tag, " mem_wr"}, 16'(mem_wr), 16'd0);
    endtask

    task automatic test_idle_word;
        apply(16'h0000);
        chk("R3 zero word alu_op", 16'(alu_op), 16'd0);
        chk("R3 zero word wr_a", 16'(wr_a), 16'd1);
        chk("R9 zero word halt", 16'(halt), 16'd0);
        chk("R9 zero word show", 16'(show), 16'd0);
        chk("R7 zero word br", 16'(br_kind), 16'd0);
    endtask

    task automatic test_fields;
        for (int s = 0; s < 8; s++) begin
            apply(mk_r(4'b0000, 3'(s), 3'(7 - s), 5'h15, 1'b1));
            chk("R1 rs", 16'(rs_idx), 16'(s));
            chk("R1 rt", 16'(rt_idx), 16'(7 - s));
            chk("R1 rs+1", 16'(rs_next_idx), 16'((s + 1) % 8));
        end
    endtask

    task automatic test_alu_r;
        logic [3:0] ops [4] = '{4'b0000, 4'b0001, 4'b0010, 4'b0011};
        for (int k = 0; k < 4; k++) begin
            for (int b = 0; b < 2; b++) begin
                apply(mk_r(ops[k], 3'd2, 3'd5, 5'h0A, 1'(b)));
                chk("R3 alu_op", 16'(alu_op), 16'(2 * k + b));
                chk("R3 wr_a", 16'(wr_a), 16'd1);
                chk("R3 wr_src", 16'(wr_src), 16'd0);
                chk("R3 b_imm", 16'(b_imm), 16'd0);
                chk("R4 wr_b", 16'(wr_b), (k == 2) ? 16'd1 : 16'd0);
                chk("R11 mem", 16'({mem_rd, mem_wr}), 16'd0);
            end
        end
    endtask

    task automatic test_wr_b_sweep;
        for (int op = 0; op < 16; op++) begin
            for (int b = 0; b < 2; b++) begin
                apply(mk_i(4'(op), 3'd6, 8'hA5, 1'(b)));
                chk("R4 wr_b sweep", 16'(wr_b), (op == 2) ? 16'd1 : 16'd0);
                chk("R11 not both mem", 16'(mem_rd & mem_wr), 16'd0);
                chk("R11 store no write", 16'(mem_wr & (wr_a | wr_b)), 16'd0);
                chk("R9 halt sweep", 16'(halt), (op == 6) ? 16'd1 : 16'd0);
                chk("R9 show sweep", 16'(show), (op == 7) ? 16'd1 : 16'd0);
            end
        end
    endtask

    task automatic test_mem;
        apply(mk_r(4'b0100, 3'd3, 3'd4, 5'h1F, 1'b0));
        chk("R5 load mem_rd", 16'(mem_rd), 16'd1);
        chk("R5 load mem_wr", 16'(mem_wr), 16'd0);
        chk("R5 load wr_a", 16'(wr_a), 16'd1);
        chk("R5 load wr_src", 16'(wr_src), 16'd1);
        chk("R5 load rt", 16'(rt_idx), 16'd4);
        apply(mk_r(4'b0100, 3'd3, 3'd4, 5'h00, 1'b1));
        chk("R5 store mem_wr", 16'(mem_wr), 16'd1);
        chk("R5 store mem_rd", 16'(mem_rd), 16'd0);
        chk("R5 store wr_a", 16'(wr_a), 16'd0);
        chk("R5 store wr_b", 16'(wr_b), 16'd0);
    endtask

    task automatic test_imm;
        apply(mk_i(4'b1000, 3'd1, 8'h80, 1'b1));
        chk("R2 addi neg", imm_val, 16'hFF80);
        chk("R6 addi alu_op", 16'(alu_op), 16'd0);
        chk("R6 addi b_imm", 16'(b_imm), 16'd1);
        chk("R6 addi wr_a", 16'(wr_a), 16'd1);
        apply(mk_i(4'b1000, 3'd1, 8'h7F, 1'b1));
        chk("R2 addi pos", imm_val, 16'h007F);
        apply(mk_i(4'b1000, 3'd1, 8'h80, 1'b0));
        chk("R2 addui", imm_val, 16'h0080);
        for (int b = 0; b < 2; b++) begin
            apply(mk_i(4'b1001, 3'd7, 8'hF0, 1'(b)));
            chk("R6 li alu_op", 16'(alu_op), 16'd8);
            chk("R6 li b_imm", 16'(b_imm), 16'd1);
            chk("R6 li wr_a", 16'(wr_a), 16'd1);
            chk("R6 li wr_src", 16'(wr_src), 16'd0);
            chk("R2 li zext", imm_val, 16'h00F0);
        end
        apply(mk_i(4'b1010, 3'd0, 8'hFF, 1'b1));
        chk("R2 branch zext", imm_val, 16'h00FF);
    endtask

    task automatic test_branches;
        apply(mk_i(4'b1010, 3'd2, 8'h1A, 1'b0));
        chk("R7 gtz", 16'(br_kind), 16'd1);
        chk_quiet("R7 gtz");
        apply(mk_i(4'b1010, 3'd2, 8'h1A, 1'b1));
        chk("R7 ltz", 16'(br_kind), 16'd2);
        chk_quiet("R7 ltz");
        apply(mk_i(4'b1011, 3'd2, 8'h1A, 1'b0));
        chk("R7 nez", 16'(br_kind), 16'd3);
        chk_quiet("R7 nez");
        apply(mk_i(4'b1011, 3'd2, 8'h1A, 1'b1));
        chk("R7 eqz", 16'(br_kind), 16'd4);
        chk_quiet("R7 eqz");
    endtask

    task automatic test_jumps;
        for (int b = 0; b < 2; b++) begin
            apply(mk_i(4'b1101, 3'd5, 8'h33, 1'(b)));
            chk("R8 j kind", 16'(br_kind), 16'd5);
            chk_quiet("R8 j");
            apply(mk_r(4'b0101, 3'd5, 3'd1, 5'h04, 1'(b)));
            chk("R8 jr kind", 16'(br_kind), 16'd6);
            chk_quiet("R8 jr");
            apply(mk_i(4'b1100, 3'd5, 8'h33, 1'(b)));
            chk("R8 jal kind", 16'(br_kind), 16'd7);
            chk("R8 jal wr_a", 16'(wr_a), 16'd1);
            chk("R8 jal wr_src", 16'(wr_src), 16'd2);
            chk("R8 jal imm", imm_val, 16'h0033);
        end
    endtask

    task automatic test_halt_show;
        apply(mk_r(4'b0110, 3'd4, 3'd0, 5'h00, 1'b1));
        chk("R9 halt", 16'(halt), 16'd1);
        chk("R9 halt show", 16'(show), 16'd0);
        chk("R9 halt br", 16'(br_kind), 16'd0);
        chk_quiet("R9 halt");
        apply(mk_r(4'b0111, 3'd4, 3'd0, 5'h00, 1'b0));
        chk("R9 show", 16'(show), 16'd1);
        chk("R9 show halt", 16'(halt), 16'd0);
        chk("R9 show rs", 16'(rs_idx), 16'd4);
        chk_quiet("R9 show");
    endtask

    task automatic test_undefined;
        logic [15:0] pats [3] = '{16'h0FFF, 16'h0000, 16'h0A55};
        for (int op = 14; op < 16; op++) begin
            for (int p = 0; p < 3; p++) begin
                apply({4'(op), 12'h000} | pats[p]);
                chk_quiet("R10 undef");
                chk("R10 undef br", 16'(br_kind), 16'd0);
                chk("R10 undef strobes", 16'({halt, show}), 16'd0);
            end
        end
    endtask

    initial begin
        insn = 16'h0000;
        test_idle_word();
        test_fields();
        test_alu_r();
        test_wr_b_sweep();
        test_mem();
        test_imm();
        test_branches();
        test_jumps();
        test_halt_show();
        test_undefined();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule